// File: doc/BRIEF.md
# External Bus Hold Arbiter

This block decides who owns the external memory bus: the local CPU, or an outside master that asks for the bus through an asynchronous hold-request line. The request is first passed through a flop synchronizer. If a bus cycle is running when the synchronized request arrives, the arbiter lets that cycle finish. If the bus is idle, it acts on the next clock. It then drops a single driver-enable that covers the address/data bus, the strobes and the chip selects. Only on the clock after that does it raise hold-acknowledge.

While the request stays high, the outside master keeps the bus and the CPU is refused new cycles through a bus-grant output. When the request falls, acknowledge drops first. The drivers come back on the following clock, and only then may a new cycle start. A request that disappears before acknowledge is treated as withdrawn.

During normal ownership the block also tracks the current bus cycle. It drives one chip-select line for each external memory block: high from the start of a cycle to that block until the cycle ends, and low whenever the bus is idle.

Top module: `bus_hold_arbiter`

## Requirements
- R1: After reset, `bus_oe` is 1, `hold_ack` is 0, all `cs` lines are 0 and `cpu_grant` is 1.
- R2: `hold_req_async` passes through `SYNC_STAGES` (default 2) flops. A request driven between clock edges does not lower `cpu_grant` after the first following rising edge.
- R3: With no bus cycle active, `bus_oe` falls at the rising edge right after the synchronized request is seen, which is the third edge after the raw input rises.
- R4: While a bus cycle is active, `bus_oe` stays 1. When hold is pending, it falls at the same edge at which `cyc_done` ends the cycle.
- R5: `hold_ack` rises exactly one clock after `bus_oe` has fallen, is never 1 while `bus_oe` is 1, and stays 1 for as long as the synchronized request stays high.
- R6: If the synchronized request falls while the drivers are off but before acknowledge, `hold_ack` never rises and `bus_oe` returns to 1 at the next edge.
- R7: On release, `hold_ack` falls while `bus_oe` is still 0, and `bus_oe` returns to 1 one clock later. `cs` then works again for a new cycle.
- R8: A start accepted at an edge (`cyc_start` with `cpu_grant`=1 and no cycle active) drives `cs[cyc_blk]`=1 from that edge, with the other lines 0, until the edge that samples `cyc_done`. A start during an active cycle is ignored.
- R9: With no bus cycle active, every `cs` line is 0.
- R10: `cpu_grant` is 0 from the edge the synchronized request is seen until the drivers are back on. A `cyc_start` during that time starts no cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hold_req_async | input | 1 | Hold request from outside master, asynchronous, active high |
| cyc_start | input | 1 | CPU asks to start a bus cycle |
| cyc_blk | input | BLK_W | Memory block targeted by the starting cycle |
| cyc_done | input | 1 | Current bus cycle ends at this edge |
| bus_oe | output | 1 | Enable for address/data, strobe and chip-select drivers |
| hold_ack | output | 1 | Bus handed to outside master |
| cpu_grant | output | 1 | CPU may start a new bus cycle |
| cyc_active | output | 1 | A bus cycle is in progress |
| cs | output | NUM_CS | Per-block chip selects, active high |

## Verification
The embedded properties check the ordering rules on every clock. Acknowledge never overlaps enabled drivers and always follows one clock of floated drivers. It falls before the drivers return, the drivers stay on during an active cycle, and chip selects stay one-hot and idle-clean. The exact edge counts can only be shown by the bench scenarios. These are the synchronizer latency, the release edge when idle versus at the end of a cycle, the withdrawn short pulse, and the refused starts during a hold.

// File: rtl/bus_hold_pkg.sv
package bus_hold_pkg;

   // Ownership states of the external bus
   typedef enum logic [2:0] {
      HB_OWN     = 3'd0,   // local CPU owns the bus, drivers on
      HB_DRAIN   = 3'd1,   // hold seen, waiting for running cycle to end
      HB_FLOAT   = 3'd2,   // drivers off, acknowledge not yet given
      HB_GRANT   = 3'd3,   // outside master owns the bus
      HB_RECLAIM = 3'd4    // acknowledge dropped, drivers still off
   } hb_state_t;

   function automatic int blk_width(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/hold_req_sync.sv
module hold_req_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_in,
   output logic sync_out
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("hold_req_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain_q <= '0;
      end else begin
         chain_q <= {chain_q[STAGES-2:0], async_in};
      end
   end

   assign sync_out = chain_q[STAGES-1];

endmodule

// File: rtl/bus_cycle_track.sv
module bus_cycle_track #(
   parameter int NUM_CS = 2,
   parameter int BLK_W  = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_req,
   input  logic              grant,
   input  logic [BLK_W-1:0]  blk,
   input  logic              done,
   output logic              cyc_active,
   output logic [NUM_CS-1:0] cs
);

   logic accept;
   logic finish;

   assign accept = start_req && grant && !cyc_active;
   assign finish = cyc_active && done;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cyc_active <= 1'b0;
      end else if (accept) begin
         cyc_active <= 1'b1;
      end else if (finish) begin
         cyc_active <= 1'b0;
      end
   end

   // One select flop per memory block
   generate
      for (genvar g = 0; g < NUM_CS; g++) begin : g_cs
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cs[g] <= 1'b0;
            end else if (accept) begin
               cs[g] <= (blk == BLK_W'(g));
            end else if (finish) begin
               cs[g] <= 1'b0;
            end
         end
      end
   endgenerate

   AST_CS_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(cs)); // R8
   AST_CS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !cyc_active |-> (cs == '0)); // R9
   AST_CS_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc_active && !done) |=> $stable(cs)); // R8

endmodule

// File: rtl/hold_fsm.sv
module hold_fsm
   import bus_hold_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic req_s,
   input  logic cyc_active,
   input  logic cyc_done,
   output logic bus_oe,
   output logic hold_ack,
   output logic cpu_grant
);

   hb_state_t st_q, st_d;

   always_comb begin
      st_d = st_q;
      case (st_q)
         HB_OWN: begin
            if (req_s) begin
               st_d = (cyc_active && !cyc_done) ? HB_DRAIN : HB_FLOAT;
            end
         end
         HB_DRAIN: begin
            if (!req_s) begin
               st_d = HB_OWN;
            end else if (cyc_done) begin
               st_d = HB_FLOAT;
            end
         end
         HB_FLOAT:   st_d = req_s ? HB_GRANT : HB_OWN;
         HB_GRANT: begin
            if (!req_s) begin
               st_d = HB_RECLAIM;
            end
         end
         HB_RECLAIM: st_d = HB_OWN;
         default:    st_d = HB_OWN;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q <= HB_OWN;
      end else begin
         st_q <= st_d;
      end
   end

   assign bus_oe    = (st_q == HB_OWN) || (st_q == HB_DRAIN);
   assign hold_ack  = (st_q == HB_GRANT);
   assign cpu_grant = (st_q == HB_OWN) && !req_s;

   AST_ACK_FLOATED: assert property (@(posedge clk) disable iff (!rst_n)
      hold_ack |-> !bus_oe); // R5
   AST_ACK_AFTER_FLOAT: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(hold_ack) |-> $past(!bus_oe)); // R5
   AST_ACK_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(hold_ack) |-> $past(req_s)); // R6
   AST_ACK_DROPS_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(hold_ack) |-> !bus_oe); // R7
   AST_DRIVERS_BACK: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(hold_ack) |=> bus_oe); // R7

endmodule

// File: rtl/bus_hold_arbiter.sv
module bus_hold_arbiter
   import bus_hold_pkg::*;
#(
   parameter int NUM_CS      = 2,
   parameter int SYNC_STAGES = 2,
   parameter int BLK_W       = blk_width(NUM_CS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hold_req_async,
   input  logic              cyc_start,
   input  logic [BLK_W-1:0]  cyc_blk,
   input  logic              cyc_done,
   output logic              bus_oe,
   output logic              hold_ack,
   output logic              cpu_grant,
   output logic              cyc_active,
   output logic [NUM_CS-1:0] cs
);

   generate
      if (NUM_CS < 1) begin : g_bad_cs
         $error("bus_hold_arbiter: NUM_CS must be at least 1");
      end
      if (BLK_W < blk_width(NUM_CS)) begin : g_bad_blk
         $error("bus_hold_arbiter: BLK_W too narrow for NUM_CS");
      end
   endgenerate

   logic req_s;

   hold_req_sync #(
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .async_in (hold_req_async),
      .sync_out (req_s)
   );

   hold_fsm u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_s      (req_s),
      .cyc_active (cyc_active),
      .cyc_done   (cyc_done),
      .bus_oe     (bus_oe),
      .hold_ack   (hold_ack),
      .cpu_grant  (cpu_grant)
   );

   bus_cycle_track #(
      .NUM_CS (NUM_CS),
      .BLK_W  (BLK_W)
   ) u_track (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_req  (cyc_start),
      .grant      (cpu_grant),
      .blk        (cyc_blk),
      .done       (cyc_done),
      .cyc_active (cyc_active),
      .cs         (cs)
   );

   AST_NO_FLOAT_MIDCYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      cyc_active |-> bus_oe); // R4
   AST_START_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc_start && !cpu_grant && !cyc_active) |=> !cyc_active); // R10
   AST_GRANT_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      (hold_ack || !bus_oe) |-> !cpu_grant); // R10

endmodule

// File: tb/bus_hold_arbiter_test.sv
module bus_hold_arbiter_test;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       hold_req_async = 1'b0;
   logic       cyc_start = 1'b0;
   logic [0:0] cyc_blk = 1'b0;
   logic       cyc_done = 1'b0;
   logic       bus_oe, hold_ack, cpu_grant, cyc_active;
   logic [1:0] cs;

   always #5 clk = ~clk;

   bus_hold_arbiter uut (
      .clk            (clk),
      .rst_n          (rst_n),
      .hold_req_async (hold_req_async),
      .cyc_start      (cyc_start),
      .cyc_blk        (cyc_blk),
      .cyc_done       (cyc_done),
      .bus_oe         (bus_oe),
      .hold_ack       (hold_ack),
      .cpu_grant      (cpu_grant),
      .cyc_active     (cyc_active),
      .cs             (cs)
   );

   typedef struct {
      int         when;
      logic       oe;
      logic       ack;
      logic [1:0] sel;
      logic       gr;
      string      tag;
   } exp_t;

   exp_t q[$];
   int   edge_cnt = 0;
   int   checks = 0;
   int   errors = 0;
   bit   done_flag = 0;

   // Monitor: after each rising edge, compare every item due now
   always @(posedge clk) begin
      #2;
      edge_cnt = edge_cnt + 1;
      while (q.size() > 0 && q[0].when <= edge_cnt) begin
         exp_t e;
         e = q.pop_front();
         checks = checks + 1;
         if (e.when < edge_cnt) begin
            errors = errors + 1;
            $display("FAIL %s: expectation for edge %0d missed (now %0d)", e.tag, e.when, edge_cnt);
         end else if (bus_oe !== e.oe || hold_ack !== e.ack || cs !== e.sel || cpu_grant !== e.gr) begin
            errors = errors + 1;
            $display("FAIL %s @edge %0d: oe/ack/cs/grant actual %b/%b/%b/%b expected %b/%b/%b/%b",
                     e.tag, edge_cnt, bus_oe, hold_ack, cs, cpu_grant, e.oe, e.ack, e.sel, e.gr);
         end
      end
   end

   task automatic expect_in(input int n, input logic oe, input logic ack,
                            input logic [1:0] sel, input logic gr, input string tag);
      exp_t e;
      e.when = edge_cnt + n;
      e.oe = oe; e.ack = ack; e.sel = sel; e.gr = gr; e.tag = tag;
      q.push_back(e);
   endtask

   task automatic drive(input logic r, input logic s, input logic b, input logic d);
      hold_req_async = r;
      cyc_start = s;
      cyc_blk = b;
      cyc_done = d;
   endtask

   task automatic nxt();
      @(negedge clk);
   endtask

   task automatic release_seq();
      drive(0, 0, 0, 0);
      expect_in(1, 0, 1, 2'b00, 0, "R5");
      expect_in(2, 0, 1, 2'b00, 0, "R7");
      expect_in(3, 0, 0, 2'b00, 0, "R7");
      expect_in(4, 1, 0, 2'b00, 1, "R7");
      repeat (4) nxt();
   endtask

   initial begin
      // reset (R1)
      repeat (2) nxt();
      expect_in(1, 1, 0, 2'b00, 1, "R1");
      nxt();
      rst_n = 1'b1;
      expect_in(1, 1, 0, 2'b00, 1, "R1");
      nxt();

      // cycle to block 1, second start ignored while active (R8, R9)
      drive(0, 1, 1, 0); expect_in(1, 1, 0, 2'b10, 1, "R8"); nxt();
      drive(0, 1, 0, 0); expect_in(1, 1, 0, 2'b10, 1, "R8"); nxt();
      drive(0, 0, 0, 1); expect_in(1, 1, 0, 2'b00, 1, "R9"); nxt();
      drive(0, 0, 0, 0); expect_in(1, 1, 0, 2'b00, 1, "R9"); nxt();
      // cycle to block 0
      drive(0, 1, 0, 0); expect_in(1, 1, 0, 2'b01, 1, "R8"); nxt();
      drive(0, 0, 0, 1); expect_in(1, 1, 0, 2'b00, 1, "R9"); nxt();
      drive(0, 0, 0, 0); nxt();

      // idle hold (R2, R3, R5, R10)
      drive(1, 0, 0, 0);
      expect_in(1, 1, 0, 2'b00, 1, "R2");
      expect_in(2, 1, 0, 2'b00, 0, "R10");
      expect_in(3, 0, 0, 2'b00, 0, "R3");
      expect_in(4, 0, 1, 2'b00, 0, "R5");
      repeat (4) nxt();
      drive(1, 1, 0, 0);
      expect_in(1, 0, 1, 2'b00, 0, "R10");
      expect_in(2, 0, 1, 2'b00, 0, "R5");
      expect_in(3, 0, 1, 2'b00, 0, "R10");
      repeat (3) nxt();
      release_seq();
      // bus usable again after reclaim (R7)
      drive(0, 1, 1, 0); expect_in(1, 1, 0, 2'b10, 1, "R7"); nxt();
      drive(0, 0, 0, 1); expect_in(1, 1, 0, 2'b00, 1, "R9"); nxt();
      drive(0, 0, 0, 0); nxt();

      // hold during active cycle (R4)
      drive(0, 1, 0, 0); expect_in(1, 1, 0, 2'b01, 1, "R8"); nxt();
      drive(1, 0, 0, 0);
      expect_in(1, 1, 0, 2'b01, 1, "R4");
      expect_in(2, 1, 0, 2'b01, 0, "R10");
      expect_in(3, 1, 0, 2'b01, 0, "R4");
      expect_in(4, 1, 0, 2'b01, 0, "R4");
      repeat (4) nxt();
      drive(1, 0, 0, 1);
      expect_in(1, 0, 0, 2'b00, 0, "R4");
      expect_in(2, 0, 1, 2'b00, 0, "R5");
      nxt();
      drive(1, 0, 0, 0);
      nxt();
      release_seq();

      // short request withdrawn before acknowledge (R6)
      drive(1, 0, 0, 0); expect_in(1, 1, 0, 2'b00, 1, "R6"); nxt();
      drive(0, 0, 0, 0);
      expect_in(1, 1, 0, 2'b00, 0, "R6");
      expect_in(2, 0, 0, 2'b00, 0, "R6");
      expect_in(3, 1, 0, 2'b00, 1, "R6");
      expect_in(4, 1, 0, 2'b00, 1, "R6");
      repeat (4) nxt();

      repeat (2) nxt();
      if (q.size() != 0) begin
         errors = errors + q.size();
         $display("FAIL end: %0d expectations never checked", q.size());
      end
      done_flag = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #2000000;
      if (!done_flag) begin
         errors = errors + 1;
         checks = checks + 1;
         $display("FAIL watchdog: run did not complete");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule